// File: doc/BRIEF.md
# Serial Bus Terminal Event Interrupt Generator

This block turns decoded command and data word strobes from a serial avionics data bus (MIL-STD-1553) into discrete interrupt pulses. Each pulse has a matching sticky status bit and, where an event carries a word, a register that holds that word. It sits after the word decoder, which has already checked sync, parity and Manchester coding. It works in one of two roles, picked by a mode input.

As a remote terminal it watches commands sent to its own address or to the broadcast address. It reports three kinds of event:
- **Transmit commands.** Reported at once.
- **Receive commands.** Reported only once the host side says the received block has been written into RAM.
- **Three mode commands.** These are synchronize, synchronize with data, and reset. The data-carrying synchronize is dropped if its data word arrives with a word-count error.

As a bus controller it reports each message as valid or invalid, using the same two shared interrupt lines that carry the terminal's block and transmit events.

A host read strobe clears all sticky bits at once.

Top module: `mb_event_irq`

## Requirements
- R1: While `rst_n` is low, every pulse output, every sticky bit and all three word registers are zero. A receive command still waiting for its commit when reset arrives is forgotten.
- R2: A command word is split as follows:
  - bits 15:11 are the terminal address;
  - bit 10 is 1 for transmit;
  - bits 9:5 are the subaddress;
  - bits 4:0 are the word count or mode code.

  In terminal mode only commands whose address equals `my_addr`, or equals 31 (broadcast), cause any event.
- R3: An addressed receive command whose subaddress is neither 0 nor 31 raises `irq_good` for one cycle. This happens in the cycle after the first later `blk_done` strobe, and not before. At the same edge `rx_cmd_reg` takes that command word.
- R4: A `blk_done` strobe with no receive command waiting causes nothing. A data word that arrives with `wd_cnt_err` set cancels the waiting receive command.
- R5: An addressed transmit command (bit 10 = 1) with a subaddress other than 0 and 31 raises `irq_xmit` in the next cycle. At the same edge `tx_cmd_reg` takes the word.
- R6: An addressed command with subaddress 0 or 31 is a mode command and never raises `irq_good` or `irq_xmit`. If its mode code is 00001 it raises `irq_sync` in the next cycle.
- R7: An addressed mode command with code 10001 arms a wait for the next word. If that word is a data word with `wd_cnt_err` low, `irq_sync_dat` is raised and the word is loaded into `sync_data_reg`. If the data word has `wd_cnt_err` high, or a command comes next instead, there is no pulse and no load.
- R8: An addressed mode command with code 01000 raises `irq_rt_reset` in the next cycle.
- R9: With `ctl_mode` = 1, a `msg_end` strobe raises `irq_good` when `msg_bad` = 0 and `irq_xmit` when `msg_bad` = 1. In this mode word strobes and `blk_done` cause nothing. With `ctl_mode` = 0, `msg_end` causes nothing.
- R10: Sticky bits `irq_stat[0..4]` belong to `irq_good`, `irq_xmit`, `irq_sync`, `irq_sync_dat` and `irq_rt_reset`, in that order. Each bit is set together with its pulse. A `host_rd` strobe clears all of them, but an event in the same cycle as the read still sets its bit.
- R11: Every pulse is one clock wide for a single triggering strobe. The word registers hold their value between their own events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_mode | input | 1 | 1 = bus controller role, 0 = remote terminal role |
| my_addr | input | 5 | Configured terminal address |
| wd_valid | input | 1 | One-cycle strobe: a decoded word is present |
| wd_is_cmd | input | 1 | 1 = command word, 0 = data word |
| wd_value | input | 16 | Decoded word value |
| wd_cnt_err | input | 1 | Word-count high or low error seen with this word |
| blk_done | input | 1 | Strobe: received block fully written into RAM |
| msg_end | input | 1 | Controller role: strobe at the end of a message |
| msg_bad | input | 1 | Qualifies `msg_end`: 1 = message invalid |
| host_rd | input | 1 | Host read strobe, clears the sticky bits |
| irq_good | output | 1 | Line 1: good block (terminal) or valid message (controller) |
| irq_xmit | output | 1 | Line 2: valid transmit command (terminal) or invalid message (controller) |
| irq_sync | output | 1 | Synchronize mode command pulse |
| irq_sync_dat | output | 1 | Synchronize-with-data pulse |
| irq_rt_reset | output | 1 | Reset mode command pulse |
| irq_stat | output | 5 | Sticky status bits |
| rx_cmd_reg | output | 16 | Receive command of the last good block |
| tx_cmd_reg | output | 16 | Last valid transmit command |
| sync_data_reg | output | 16 | Last accepted synchronize data word |

## Verification
The bench builds the block with the package defaults: a 16-bit word, a 5-bit address and five interrupt sources. It drives `my_addr` to 5, so that in a single run it can send commands with a matching address, a foreign address and the broadcast address. It uses both mode-command subaddresses, 0 and 31. It lets a word-count error cancel both a waiting receive and a waiting synchronize data word. It applies a reset while a receive is waiting, and issues a host read in the same cycle as a new event.

// File: rtl/mb_irq_pkg.sv
package mb_irq_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int SUB_W   = 5;
  localparam int CODE_W  = 5;
  localparam int NUM_IRQ = 5;

  localparam int ADDR_LSB = WORD_W - ADDR_W;
  localparam int TX_BIT   = ADDR_LSB - 1;
  localparam int SUB_LSB  = TX_BIT - SUB_W;

  localparam logic [ADDR_W-1:0] BCAST_ADDR   = '1;
  localparam logic [SUB_W-1:0]  SUB_MODE_LO  = '0;
  localparam logic [SUB_W-1:0]  SUB_MODE_HI  = '1;
  localparam logic [CODE_W-1:0] MC_SYNC      = 5'b00001;
  localparam logic [CODE_W-1:0] MC_SYNC_DATA = 5'b10001;
  localparam logic [CODE_W-1:0] MC_RESET     = 5'b01000;

  // interrupt source index, also sticky bit position
  localparam int IX_GOOD = 0;
  localparam int IX_XMIT = 1;
  localparam int IX_SYNC = 2;
  localparam int IX_SDAT = 3;
  localparam int IX_RST  = 4;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [NUM_IRQ-1:0] irq_vec_t;

  function automatic logic [ADDR_W-1:0] f_addr(input word_t w);
    return w[WORD_W-1:ADDR_LSB];
  endfunction

  function automatic logic f_is_tx(input word_t w);
    return w[TX_BIT];
  endfunction

  function automatic logic [SUB_W-1:0] f_sub(input word_t w);
    return w[TX_BIT-1:SUB_LSB];
  endfunction

  function automatic logic [CODE_W-1:0] f_code(input word_t w);
    return w[CODE_W-1:0];
  endfunction

  function automatic logic f_is_mode(input word_t w);
    return (f_sub(w) == SUB_MODE_LO) || (f_sub(w) == SUB_MODE_HI);
  endfunction

  function automatic logic f_hits(input word_t w, input logic [ADDR_W-1:0] mine);
    return (f_addr(w) == mine) || (f_addr(w) == BCAST_ADDR);
  endfunction
endpackage

// File: rtl/mb_cmd_decode.sv
module mb_cmd_decode
  import mb_irq_pkg::*;
(
  input  logic              rt_en,
  input  logic              wd_valid,
  input  logic              wd_is_cmd,
  input  word_t             wd_value,
  input  logic [ADDR_W-1:0] my_addr,
  output logic              any_cmd,
  output logic              data_vld,
  output logic              hit_rx,
  output logic              hit_tx,
  output logic              hit_sync,
  output logic              hit_sd,
  output logic              hit_rst
);
  logic cmd_ok, is_mode;
  logic [CODE_W-1:0] code;

  always_comb begin
    any_cmd  = rt_en & wd_valid & wd_is_cmd;
    data_vld = rt_en & wd_valid & ~wd_is_cmd;
    cmd_ok   = any_cmd & f_hits(wd_value, my_addr);
    is_mode  = f_is_mode(wd_value);
    code     = f_code(wd_value);
    hit_rx   = cmd_ok & ~is_mode & ~f_is_tx(wd_value);
    hit_tx   = cmd_ok & ~is_mode &  f_is_tx(wd_value);
    hit_sync = cmd_ok & is_mode & (code == MC_SYNC);
    hit_sd   = cmd_ok & is_mode & (code == MC_SYNC_DATA);
    hit_rst  = cmd_ok & is_mode & (code == MC_RESET);
  end
endmodule

// File: rtl/mb_rt_seq.sv
module mb_rt_seq
  import mb_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rt_en,
  input  logic  hit_rx,
  input  logic  hit_sd,
  input  logic  any_cmd,
  input  logic  data_vld,
  input  logic  cnt_err,
  input  logic  blk_done,
  input  word_t wd_value,
  output logic  ev_blk,
  output logic  ev_sd,
  output word_t pend_cmd
);
  logic rx_pend, sd_wait;

  assign ev_blk = rt_en & blk_done & rx_pend;
  assign ev_sd  = data_vld & sd_wait & ~cnt_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pend  <= 1'b0;
      pend_cmd <= '0;
    end else if (hit_rx) begin
      rx_pend  <= 1'b1;
      pend_cmd <= wd_value;
    end else if (ev_blk || (data_vld && cnt_err)) begin
      rx_pend  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sd_wait <= 1'b0;
    else if (hit_sd)             sd_wait <= 1'b1;
    else if (any_cmd | data_vld) sd_wait <= 1'b0;
  end
endmodule

// File: rtl/mb_irq_out.sv
module mb_irq_out
  import mb_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t ev,
  input  logic     host_rd,
  input  logic     ld_rx,
  input  logic     ld_tx,
  input  logic     ld_sd,
  input  word_t    rx_word,
  input  word_t    tx_word,
  input  word_t    sd_word,
  output irq_vec_t irq_q,
  output irq_vec_t stat_q,
  output word_t    rx_reg,
  output word_t    tx_reg,
  output word_t    sd_reg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      stat_q <= '0;
    end else begin
      irq_q  <= ev;
      stat_q <= (host_rd ? '0 : stat_q) | ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_reg <= '0;
      tx_reg <= '0;
      sd_reg <= '0;
    end else begin
      if (ld_rx) rx_reg <= rx_word;
      if (ld_tx) tx_reg <= tx_word;
      if (ld_sd) sd_reg <= sd_word;
    end
  end
endmodule

// File: rtl/mb_event_irq.sv
module mb_event_irq
  import mb_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_mode,
  input  logic [ADDR_W-1:0]     my_addr,
  input  logic                  wd_valid,
  input  logic                  wd_is_cmd,
  input  logic [WORD_W-1:0]     wd_value,
  input  logic                  wd_cnt_err,
  input  logic                  blk_done,
  input  logic                  msg_end,
  input  logic                  msg_bad,
  input  logic                  host_rd,
  output logic                  irq_good,
  output logic                  irq_xmit,
  output logic                  irq_sync,
  output logic                  irq_sync_dat,
  output logic                  irq_rt_reset,
  output logic [NUM_IRQ-1:0]    irq_stat,
  output logic [WORD_W-1:0]     rx_cmd_reg,
  output logic [WORD_W-1:0]     tx_cmd_reg,
  output logic [WORD_W-1:0]     sync_data_reg
);
  logic rt_en;
  logic any_cmd, data_vld, hit_rx, hit_tx, hit_sync, hit_sd, hit_rst;
  logic ev_blk, ev_sd, bc_ok, bc_bad;
  word_t pend_cmd;
  irq_vec_t ev_vec, irq_q;

  assign rt_en  = ~ctl_mode;
  assign bc_ok  = ctl_mode & msg_end & ~msg_bad;
  assign bc_bad = ctl_mode & msg_end &  msg_bad;

  mb_cmd_decode u_dec (
    .rt_en(rt_en), .wd_valid(wd_valid), .wd_is_cmd(wd_is_cmd),
    .wd_value(wd_value), .my_addr(my_addr),
    .any_cmd(any_cmd), .data_vld(data_vld), .hit_rx(hit_rx), .hit_tx(hit_tx),
    .hit_sync(hit_sync), .hit_sd(hit_sd), .hit_rst(hit_rst)
  );

  mb_rt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rt_en(rt_en), .hit_rx(hit_rx), .hit_sd(hit_sd),
    .any_cmd(any_cmd), .data_vld(data_vld), .cnt_err(wd_cnt_err),
    .blk_done(blk_done), .wd_value(wd_value),
    .ev_blk(ev_blk), .ev_sd(ev_sd), .pend_cmd(pend_cmd)
  );

  always_comb begin
    ev_vec          = '0;
    ev_vec[IX_GOOD] = ev_blk | bc_ok;
    ev_vec[IX_XMIT] = hit_tx | bc_bad;
    ev_vec[IX_SYNC] = hit_sync;
    ev_vec[IX_SDAT] = ev_sd;
    ev_vec[IX_RST]  = hit_rst;
  end

  mb_irq_out u_out (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .host_rd(host_rd),
    .ld_rx(ev_blk), .ld_tx(hit_tx), .ld_sd(ev_sd),
    .rx_word(pend_cmd), .tx_word(wd_value), .sd_word(wd_value),
    .irq_q(irq_q), .stat_q(irq_stat),
    .rx_reg(rx_cmd_reg), .tx_reg(tx_cmd_reg), .sd_reg(sync_data_reg)
  );

  assign irq_good     = irq_q[IX_GOOD];
  assign irq_xmit     = irq_q[IX_XMIT];
  assign irq_sync     = irq_q[IX_SYNC];
  assign irq_sync_dat = irq_q[IX_SDAT];
  assign irq_rt_reset = irq_q[IX_RST];
endmodule

// File: rtl/mb_event_irq_chk.sv
module mb_event_irq_chk
  import mb_irq_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     ctl_mode,
  input logic     blk_done,
  input logic     msg_end,
  input logic     host_rd,
  input irq_vec_t ev_vec,
  input logic     irq_good,
  input logic     irq_xmit,
  input logic     irq_sync,
  input logic     irq_sync_dat,
  input logic     irq_rt_reset,
  input irq_vec_t irq_stat,
  input word_t    rx_cmd_reg,
  input word_t    tx_cmd_reg,
  input word_t    sync_data_reg
);
  irq_vec_t pulses;
  assign pulses = {irq_rt_reset, irq_sync_dat, irq_sync, irq_xmit, irq_good};

  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_cmd_reg) |-> irq_good);
  p_good_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_good |-> ($past(blk_done) || $past(ctl_mode && msg_end)));
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_cmd_reg) |-> irq_xmit);
  p_sd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync_data_reg) |-> irq_sync_dat);
  p_bc_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_mode) |-> !(irq_sync || irq_sync_dat || irq_rt_reset));
  p_stat_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pulses & ~irq_stat) == '0);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && ev_vec == '0) |=> irq_stat == '0);
endmodule

bind mb_event_irq mb_event_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .blk_done(blk_done),
  .msg_end(msg_end), .host_rd(host_rd), .ev_vec(ev_vec),
  .irq_good(irq_good), .irq_xmit(irq_xmit), .irq_sync(irq_sync),
  .irq_sync_dat(irq_sync_dat), .irq_rt_reset(irq_rt_reset),
  .irq_stat(irq_stat), .rx_cmd_reg(rx_cmd_reg), .tx_cmd_reg(tx_cmd_reg),
  .sync_data_reg(sync_data_reg)
);

// File: tb/mb_event_irq_test.sv
module mb_event_irq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_mode = 1'b0;
  logic [4:0] my_addr = 5'd5;
  logic wd_valid = 1'b0, wd_is_cmd = 1'b0, wd_cnt_err = 1'b0;
  logic [15:0] wd_value = '0;
  logic blk_done = 1'b0, msg_end = 1'b0, msg_bad = 1'b0, host_rd = 1'b0;
  logic irq_good, irq_xmit, irq_sync, irq_sync_dat, irq_rt_reset;
  logic [4:0] irq_stat;
  logic [15:0] rx_cmd_reg, tx_cmd_reg, sync_data_reg;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mb_event_irq uut (
    .clk(clk), .rst_n(rst_n), .ctl_mode(ctl_mode), .my_addr(my_addr),
    .wd_valid(wd_valid), .wd_is_cmd(wd_is_cmd), .wd_value(wd_value),
    .wd_cnt_err(wd_cnt_err), .blk_done(blk_done), .msg_end(msg_end),
    .msg_bad(msg_bad), .host_rd(host_rd),
    .irq_good(irq_good), .irq_xmit(irq_xmit), .irq_sync(irq_sync),
    .irq_sync_dat(irq_sync_dat), .irq_rt_reset(irq_rt_reset),
    .irq_stat(irq_stat), .rx_cmd_reg(rx_cmd_reg), .tx_cmd_reg(tx_cmd_reg),
    .sync_data_reg(sync_data_reg)
  );

  // command word per R2: address, transmit bit, subaddress, count/mode code
  function automatic logic [15:0] cw(input logic [4:0] a, input logic t,
                                     input logic [4:0] s, input logic [4:0] c);
    return {a, t, s, c};
  endfunction

  // vector: req, ctl, cmd, vld, cerr, done, mend, mbad, value, expected pulses
  function automatic logic [31:0] mk(input logic [3:0] rq, input logic ctl,
      input logic cmd, input logic vld, input logic cerr, input logic dn,
      input logic me, input logic mb, input logic [15:0] v, input logic [4:0] ex);
    return {rq, ctl, cmd, vld, cerr, dn, me, mb, v, ex};
  endfunction

  // expected pulse order {rt_reset, sync_dat, sync, xmit, good}
  localparam int NV = 24;
  localparam logic [31:0] TBL [NV] = '{
    mk(4'd3, 0,1,1,0,0,0,0, cw(5,0,3,2),   5'b00000), // R3 receive, no pulse yet
    mk(4'd3, 0,0,1,0,0,0,0, 16'h1111,      5'b00000), // R3 data
    mk(4'd3, 0,0,1,0,0,0,0, 16'h2222,      5'b00000), // R3 data
    mk(4'd3, 0,0,0,0,1,0,0, 16'h0000,      5'b00001), // R3 commit -> good
    mk(4'd4, 0,0,0,0,1,0,0, 16'h0000,      5'b00000), // R4 commit without pending
    mk(4'd5, 0,1,1,0,0,0,0, cw(5,1,4,1),   5'b00010), // R5 transmit
    mk(4'd2, 0,1,1,0,0,0,0, cw(6,1,4,1),   5'b00000), // R2 foreign address
    mk(4'd2, 0,1,1,0,0,0,0, cw(31,0,2,1),  5'b00000), // R2 broadcast receive
    mk(4'd2, 0,0,0,0,1,0,0, 16'h0000,      5'b00001), // R2 broadcast commit
    mk(4'd6, 0,1,1,0,0,0,0, cw(5,0,0,1),   5'b00100), // R6 sync, subaddress 0
    mk(4'd8, 0,1,1,0,0,0,0, cw(5,1,31,8),  5'b10000), // R8 reset, subaddress 31
    mk(4'd2, 0,1,1,0,0,0,0, cw(9,0,0,8),   5'b00000), // R2 foreign mode cmd
    mk(4'd7, 0,1,1,0,0,0,0, cw(5,0,0,17),  5'b00000), // R7 sync with data armed
    mk(4'd7, 0,0,1,0,0,0,0, 16'hBEEF,      5'b01000), // R7 data accepted
    mk(4'd7, 0,1,1,0,0,0,0, cw(31,0,31,17),5'b00000), // R7 broadcast arm
    mk(4'd7, 0,0,1,1,0,0,0, 16'h0BAD,      5'b00000), // R7 count error suppresses
    mk(4'd4, 0,1,1,0,0,0,0, cw(5,0,7,3),   5'b00000), // R4 receive
    mk(4'd4, 0,0,1,1,0,0,0, 16'h3333,      5'b00000), // R4 count error cancels
    mk(4'd4, 0,0,0,0,1,0,0, 16'h0000,      5'b00000), // R4 commit after cancel
    mk(4'd9, 1,0,0,0,0,1,0, 16'h0000,      5'b00001), // R9 valid message
    mk(4'd9, 1,0,0,0,0,1,1, 16'h0000,      5'b00010), // R9 invalid message
    mk(4'd9, 1,1,1,0,0,0,0, cw(5,1,4,1),   5'b00000), // R9 words ignored
    mk(4'd9, 1,0,0,0,1,0,0, 16'h0000,      5'b00000), // R9 commit ignored
    mk(4'd9, 0,0,0,0,0,1,0, 16'h0000,      5'b00000)  // R9 msg_end ignored in terminal
  };

  function automatic logic [4:0] pulses();
    return {irq_rt_reset, irq_sync_dat, irq_sync, irq_xmit, irq_good};
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle();
    wd_valid = 0; wd_is_cmd = 0; wd_cnt_err = 0; wd_value = '0;
    blk_done = 0; msg_end = 0; msg_bad = 0; host_rd = 0; ctl_mode = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 pulses", {27'd0, pulses()}, 32'd0);
    check("R1 stat", {27'd0, irq_stat}, 32'd0);
    check("R1 regs", {rx_cmd_reg, tx_cmd_reg | sync_data_reg}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = TBL[i];
      ctl_mode   = v[27];
      wd_is_cmd  = v[26];
      wd_valid   = v[25];
      wd_cnt_err = v[24];
      blk_done   = v[23];
      msg_end    = v[22];
      msg_bad    = v[21];
      wd_value   = v[20:5];
      @(negedge clk);
      check($sformatf("R%0d step %0d", v[31:28], i), {27'd0, pulses()}, {27'd0, v[4:0]});
    end
    idle();
    @(negedge clk);
    check("R11 pulse ends", {27'd0, pulses()}, 32'd0);
    check("R3 rx_cmd_reg", {16'd0, rx_cmd_reg}, {16'd0, cw(31,0,2,1)});
    check("R5 tx_cmd_reg", {16'd0, tx_cmd_reg}, {16'd0, cw(5,1,4,1)});
    check("R7 sync_data_reg", {16'd0, sync_data_reg}, 32'h0000BEEF);
    check("R10 all sticky", {27'd0, irq_stat}, 32'h1F);

    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    check("R10 read clears", {27'd0, irq_stat}, 32'd0);

    // R10 read in the same cycle as a transmit command
    host_rd = 1; wd_valid = 1; wd_is_cmd = 1; wd_value = cw(5,1,7,3);
    @(negedge clk);
    idle();
    check("R10 read with event", {27'd0, irq_stat}, 32'h02);
    check("R5 second transmit", {16'd0, tx_cmd_reg}, {16'd0, cw(5,1,7,3)});

    // R1 reset drops a waiting receive
    wd_valid = 1; wd_is_cmd = 1; wd_value = cw(5,0,9,4);
    @(negedge clk);
    idle();
    rst_n = 0;
    @(negedge clk);
    check("R1 reset regs", {tx_cmd_reg, 11'd0, irq_stat}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    blk_done = 1;
    @(negedge clk);
    blk_done = 0;
    check("R1 pending forgotten", {27'd0, pulses()}, 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule